// File: doc/BRIEF.md
# Power Domain Sleep and Wake Controller

This block manages one power domain that holds a parameterised number of modules. Each module has an interface clock enable, a functional clock enable and a wake-up input. Software programs the controller through a small write port with combinational readback. It sets a two-bit transition mode, the low-power target (retention or off), per-module wake enables, per-module processor group selects, the per-module clock enables, and masks for sleep and wake dependencies on neighbouring domains.

A sleep transition may begin only when every clock of every module has been turned off. While the transition runs, the controller holds a request to the power-switch model and keeps all clocks gated until the request is acknowledged. It then reports the target state. A qualifying wake-up brings the domain back. The controller reopens every interface clock first and every functional clock one cycle later. A wake-up that arrives during a transition is held and is acted on as soon as the acknowledge comes. An inaccessibility flag reads 1 whenever the domain is anywhere other than fully on.

Top module: `pwrdom_ctrl`

## Requirements
- R1: After reset the domain reports on (pwr_state 0), inaccessible is 0, pwr_req is 0, all interface and functional clock enables read 1, and the control, wake enable, group select, wake status and dependency registers read 0.
- R2: A sleep transition starts only when the interface and functional clock enable registers of all modules are 0. A single module clock left on, of either kind, keeps the domain on.
- R3: The transition mode field (register 0, bits 1:0) decodes as follows. 3 is automatic sleep, 1 is forced sleep, 2 is forced wake, and 0 disables sleep entirely. Forced sleep ignores sleep dependencies.
- R4: In automatic mode, sleep is blocked while any neighbour flagged in the sleep dependency mask (register 6) has its dom_busy bit high. Busy bits outside the mask have no effect.
- R5: During a transition pwr_req is 1, pwr_state is 1 and all clock enables are 0, and this holds until pwr_ack is seen. On the acknowledge the domain reports 2 (retention) when the target bit (register 0, bit 2) was 0 at sleep start, or 3 (off) when it was 1. Changing the bit during the transition does not change the outcome.
- R6: A module wake-up is honoured only when both that module's wake enable bit (register 1) and its group select bit (register 2) are 1.
- R7: On a wake-up from low power, the next cycle shows every interface clock on, every functional clock off and pwr_state 1. One cycle later every functional clock is on and pwr_state is 0.
- R8: A qualified wake-up sets the module's wake status bit (register 3) in any state. Writing 0 to a bit position of register 3 clears that bit and writing 1 leaves it unchanged. A wake-up in the same cycle as a clear leaves the bit set.
- R9: inaccessible is 1 in every state except fully on, including the cycle in which only the interface clocks have returned.
- R10: From low power, the domain wakes when any neighbour flagged in the wake dependency mask (register 7) pulses its dom_wake bit. Unflagged neighbours have no effect.
- R11: Setting the mode field to 2 while in low power starts the wake sequence.
- R12: A qualified wake-up during a transition leaves pwr_req high until the acknowledge. The domain then enters the wake sequence directly, and the wake status bit is kept.
- R13: The register addresses are 0 for control, 1 for wake enable, 2 for group select, 3 for wake status, 4 for interface clock enables, 5 for functional clock enables, 6 for the sleep dependency mask and 7 for the wake dependency mask. reg_rdata returns the addressed register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the addressed register |
| mod_wake | input | NUM_MODS | Per-module wake-up events |
| dom_busy | input | NUM_DEPS | Neighbour domains that are active |
| dom_wake | input | NUM_DEPS | Neighbour domains requesting a wake-up |
| pwr_ack | input | 1 | Power-switch acknowledge |
| pwr_req | output | 1 | Power-switch request, high during a sleep transition |
| iclk_en | output | NUM_MODS | Interface clock enables |
| fclk_en | output | NUM_MODS | Functional clock enables |
| pwr_state | output | 2 | 0 on, 1 moving, 2 retention, 3 off |
| inaccessible | output | 1 | 1 whenever the domain is not fully on |

## Verification
The bench builds the controller with three modules and two neighbour domains. With that size, all 64 combinations of interface and functional clock enables can be swept to show that only the all-off pattern lets sleep begin. The same size lets every module be tried with all four pairings of wake enable and group select. Two neighbours are enough to show both a masked and an unmasked dependency for sleep blocking and for wake-up. The remaining cases are driven in directed form: target latching, a wake-up arriving mid-transition, and a status clear colliding with a set.

// File: rtl/pwrdom_pkg.sv
package pwrdom_pkg;

    typedef enum logic [1:0] {
        TM_NONE   = 2'd0,
        TM_FSLEEP = 2'd1,
        TM_FWAKE  = 2'd2,
        TM_AUTO   = 2'd3
    } trans_mode_e;

    typedef enum logic [1:0] {
        ST_ON     = 2'd0,
        ST_TRANS  = 2'd1,
        ST_LOW    = 2'd2,
        ST_WAKE_I = 2'd3
    } pd_state_e;

    typedef enum logic [1:0] {
        PS_ON     = 2'd0,
        PS_MOVING = 2'd1,
        PS_RET    = 2'd2,
        PS_OFF    = 2'd3
    } pwr_report_e;

    typedef struct packed {
        logic        lp_off;
        trans_mode_e mode;
    } ctrl_t;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_WKEN  = 3'd1;
    localparam logic [2:0] A_GRP   = 3'd2;
    localparam logic [2:0] A_WKST  = 3'd3;
    localparam logic [2:0] A_ICLK  = 3'd4;
    localparam logic [2:0] A_FCLK  = 3'd5;
    localparam logic [2:0] A_SLDEP = 3'd6;
    localparam logic [2:0] A_WKDEP = 3'd7;

    function automatic pwr_report_e report_of(pd_state_e st, logic off);
        case (st)
            ST_ON:   return PS_ON;
            ST_LOW:  return off ? PS_OFF : PS_RET;
            default: return PS_MOVING;
        endcase
    endfunction

endpackage

// File: rtl/pwrdom_regs.sv
module pwrdom_regs
    import pwrdom_pkg::*;
#(
    parameter int NUM_MODS = 4,
    parameter int NUM_DEPS = 2,
    parameter int REG_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [2:0]          addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [NUM_MODS-1:0] mod_wake,
    input  logic                hw_iclk_on,
    input  logic                hw_fclk_on,
    output ctrl_t               ctrl,
    output logic [NUM_MODS-1:0] iclk_sw,
    output logic [NUM_MODS-1:0] fclk_sw,
    output logic [NUM_DEPS-1:0] slpdep,
    output logic [NUM_DEPS-1:0] wkdep,
    output logic [NUM_MODS-1:0] qual_ev,
    output logic [REG_W-1:0]    rdata
);

    logic [NUM_MODS-1:0] wken;
    logic [NUM_MODS-1:0] grpsel;
    logic [NUM_MODS-1:0] wkst;
    logic [NUM_MODS-1:0] clr_mask;

    assign qual_ev  = mod_wake & wken & grpsel;
    assign clr_mask = (we && addr == A_WKST) ? ~wdata[NUM_MODS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '{lp_off: 1'b0, mode: TM_NONE};
            wken    <= '0;
            grpsel  <= '0;
            iclk_sw <= '1;
            fclk_sw <= '1;
            slpdep  <= '0;
            wkdep   <= '0;
        end else begin
            if (we) begin
                case (addr)
                    A_CTRL: begin
                        ctrl.mode   <= trans_mode_e'(wdata[1:0]);
                        ctrl.lp_off <= wdata[2];
                    end
                    A_WKEN:  wken    <= wdata[NUM_MODS-1:0];
                    A_GRP:   grpsel  <= wdata[NUM_MODS-1:0];
                    A_ICLK:  iclk_sw <= wdata[NUM_MODS-1:0];
                    A_FCLK:  fclk_sw <= wdata[NUM_MODS-1:0];
                    A_SLDEP: slpdep  <= wdata[NUM_DEPS-1:0];
                    A_WKDEP: wkdep   <= wdata[NUM_DEPS-1:0];
                    default: ;
                endcase
            end
            if (hw_iclk_on) iclk_sw <= '1;
            if (hw_fclk_on) fclk_sw <= '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wkst <= '0;
        else     wkst <= (wkst & ~clr_mask) | qual_ev;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[2:0]          = {ctrl.lp_off, ctrl.mode};
            A_WKEN:  rdata[NUM_MODS-1:0] = wken;
            A_GRP:   rdata[NUM_MODS-1:0] = grpsel;
            A_WKST:  rdata[NUM_MODS-1:0] = wkst;
            A_ICLK:  rdata[NUM_MODS-1:0] = iclk_sw;
            A_FCLK:  rdata[NUM_MODS-1:0] = fclk_sw;
            A_SLDEP: rdata[NUM_DEPS-1:0] = slpdep;
            default: rdata[NUM_DEPS-1:0] = wkdep;
        endcase
    end

    // R8
    wkst_set_src_chk: assert property (@(posedge clk) disable iff (rst)
        ((wkst & ~$past(wkst)) & ~$past(qual_ev)) == '0);

    // R7
    fclk_after_iclk_chk: assert property (@(posedge clk) disable iff (rst)
        hw_fclk_on |-> (iclk_sw == '1));

endmodule

// File: rtl/pwrdom_gate.sv
module pwrdom_gate #(
    parameter int NUM_MODS = 4
) (
    input  logic [NUM_MODS-1:0] iclk_sw,
    input  logic [NUM_MODS-1:0] fclk_sw,
    input  logic                iclk_open,
    input  logic                fclk_open,
    output logic [NUM_MODS-1:0] iclk_en,
    output logic [NUM_MODS-1:0] fclk_en,
    output logic                all_gated
);

    logic [NUM_MODS-1:0] mod_idle;

    for (genvar i = 0; i < NUM_MODS; i++) begin : g_mod
        assign iclk_en[i]  = iclk_sw[i] & iclk_open;
        assign fclk_en[i]  = fclk_sw[i] & fclk_open;
        assign mod_idle[i] = ~iclk_sw[i] & ~fclk_sw[i];
    end

    assign all_gated = &mod_idle;

endmodule

// File: rtl/pwrdom_fsm.sv
module pwrdom_fsm
    import pwrdom_pkg::*;
#(
    parameter int NUM_DEPS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  ctrl_t               ctrl,
    input  logic                all_gated,
    input  logic                any_qual,
    input  logic [NUM_DEPS-1:0] slpdep,
    input  logic [NUM_DEPS-1:0] wkdep,
    input  logic [NUM_DEPS-1:0] dom_busy,
    input  logic [NUM_DEPS-1:0] dom_wake,
    input  logic                pwr_ack,
    output logic                pwr_req,
    output logic                iclk_open,
    output logic                fclk_open,
    output logic                hw_iclk_on,
    output logic                hw_fclk_on,
    output pwr_report_e         pwr_state,
    output logic                inaccessible
);

    pd_state_e state;
    logic      off_q;
    logic      pend;
    logic      sleep_blocked;
    logic      dep_wake;
    logic      wake_cond;
    logic      start_sleep;
    logic      ack_to_wake;

    assign sleep_blocked = |(slpdep & dom_busy);
    assign dep_wake      = |(wkdep & dom_wake);
    assign wake_cond     = any_qual | dep_wake | (ctrl.mode == TM_FWAKE);
    assign start_sleep   = all_gated && !wake_cond &&
                           ((ctrl.mode == TM_AUTO && !sleep_blocked) ||
                            ctrl.mode == TM_FSLEEP);
    assign ack_to_wake   = pwr_ack && (pend || wake_cond);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ON;
            off_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            case (state)
                ST_ON: begin
                    if (start_sleep) begin
                        state <= ST_TRANS;
                        off_q <= ctrl.lp_off;
                        pend  <= 1'b0;
                    end
                end
                ST_TRANS: begin
                    if (pwr_ack) begin
                        state <= ack_to_wake ? ST_WAKE_I : ST_LOW;
                        pend  <= 1'b0;
                    end else if (wake_cond) begin
                        pend <= 1'b1;
                    end
                end
                ST_LOW: begin
                    if (wake_cond) state <= ST_WAKE_I;
                end
                default: state <= ST_ON;
            endcase
        end
    end

    assign hw_iclk_on   = (state == ST_LOW && wake_cond) ||
                          (state == ST_TRANS && ack_to_wake);
    assign hw_fclk_on   = (state == ST_WAKE_I);
    assign iclk_open    = (state == ST_ON) || (state == ST_WAKE_I);
    assign fclk_open    = (state == ST_ON);
    assign pwr_req      = (state == ST_TRANS);
    assign pwr_state    = report_of(state, off_q);
    assign inaccessible = (state != ST_ON);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_req && !pwr_ack) |=> pwr_req);

    // R2
    sleep_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_req) |-> $past(all_gated));

    // R11
    fwake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW && ctrl.mode == TM_FWAKE) |=> (state == ST_WAKE_I));

endmodule

// File: rtl/pwrdom_ctrl.sv
module pwrdom_ctrl
    import pwrdom_pkg::*;
#(
    parameter int NUM_MODS = 4,
    parameter int NUM_DEPS = 2,
    parameter int REG_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_MODS-1:0] mod_wake,
    input  logic [NUM_DEPS-1:0] dom_busy,
    input  logic [NUM_DEPS-1:0] dom_wake,
    input  logic                pwr_ack,
    output logic                pwr_req,
    output logic [NUM_MODS-1:0] iclk_en,
    output logic [NUM_MODS-1:0] fclk_en,
    output logic [1:0]          pwr_state,
    output logic                inaccessible
);

    ctrl_t               ctrl;
    logic [NUM_MODS-1:0] iclk_sw;
    logic [NUM_MODS-1:0] fclk_sw;
    logic [NUM_DEPS-1:0] slpdep;
    logic [NUM_DEPS-1:0] wkdep;
    logic [NUM_MODS-1:0] qual_ev;
    logic                hw_iclk_on;
    logic                hw_fclk_on;
    logic                iclk_open;
    logic                fclk_open;
    logic                all_gated;
    pwr_report_e         rep;

    pwrdom_regs #(.NUM_MODS(NUM_MODS), .NUM_DEPS(NUM_DEPS), .REG_W(REG_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .mod_wake   (mod_wake),
        .hw_iclk_on (hw_iclk_on),
        .hw_fclk_on (hw_fclk_on),
        .ctrl       (ctrl),
        .iclk_sw    (iclk_sw),
        .fclk_sw    (fclk_sw),
        .slpdep     (slpdep),
        .wkdep      (wkdep),
        .qual_ev    (qual_ev),
        .rdata      (reg_rdata)
    );

    pwrdom_gate #(.NUM_MODS(NUM_MODS)) gate_i (
        .iclk_sw   (iclk_sw),
        .fclk_sw   (fclk_sw),
        .iclk_open (iclk_open),
        .fclk_open (fclk_open),
        .iclk_en   (iclk_en),
        .fclk_en   (fclk_en),
        .all_gated (all_gated)
    );

    pwrdom_fsm #(.NUM_DEPS(NUM_DEPS)) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl),
        .all_gated    (all_gated),
        .any_qual     (|qual_ev),
        .slpdep       (slpdep),
        .wkdep        (wkdep),
        .dom_busy     (dom_busy),
        .dom_wake     (dom_wake),
        .pwr_ack      (pwr_ack),
        .pwr_req      (pwr_req),
        .iclk_open    (iclk_open),
        .fclk_open    (fclk_open),
        .hw_iclk_on   (hw_iclk_on),
        .hw_fclk_on   (hw_fclk_on),
        .pwr_state    (rep),
        .inaccessible (inaccessible)
    );

    assign pwr_state = rep;

    // R5
    trans_clk_off_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_req |-> (iclk_en == '0 && fclk_en == '0));

    // R9
    access_chk: assert property (@(posedge clk) disable iff (rst)
        (fclk_en != '0) |-> !inaccessible);

endmodule

// File: tb/pwrdom_ctrl_tb.sv
module pwrdom_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 3;
    localparam int ND = 2;
    localparam int RW = 8;
    localparam logic [NM-1:0] ALL_M = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic [NM-1:0] mod_wake = '0;
    logic [ND-1:0] dom_busy = '0;
    logic [ND-1:0] dom_wake = '0;
    logic          pwr_ack = 1'b0;
    logic          pwr_req;
    logic [NM-1:0] iclk_en;
    logic [NM-1:0] fclk_en;
    logic [1:0]    pwr_state;
    logic          inaccessible;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdom_ctrl #(.NUM_MODS(NM), .NUM_DEPS(ND), .REG_W(RW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .mod_wake     (mod_wake),
        .dom_busy     (dom_busy),
        .dom_wake     (dom_wake),
        .pwr_ack      (pwr_ack),
        .pwr_req      (pwr_req),
        .iclk_en      (iclk_en),
        .fclk_en      (fclk_en),
        .pwr_state    (pwr_state),
        .inaccessible (inaccessible)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = RW'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic go_sleep(input bit off);
        wr(0, 0);
        wr(4, 0);
        wr(5, 0);
        wr(0, off ? 7 : 3);
        @(negedge clk);
        chk("R2 sleep start", pwr_req, 1);
    endtask

    task automatic do_ack();
        pwr_ack = 1'b1;
        @(negedge clk);
        pwr_ack = 1'b0;
    endtask

    task automatic force_wake();
        wr(0, 2);
        @(negedge clk);
        chk("R11 forced wake moving", pwr_state, 1);
        @(negedge clk);
        chk("R11 forced wake on", pwr_state, 0);
        wr(0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pwr_state", pwr_state, 0);
        chk("R1 inaccessible", inaccessible, 0);
        chk("R1 pwr_req", pwr_req, 0);
        chk("R1 iclk_en", iclk_en, ALL_M);
        chk("R1 fclk_en", fclk_en, ALL_M);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 R13 reset reg", v, (a == 4 || a == 5) ? ALL_M : 0);
        end

        // R13 readback
        wr(1, 5); wr(2, 6); wr(6, 2); wr(7, 1);
        rd(1, v); chk("R13 wken", v, 5);
        rd(2, v); chk("R13 grpsel", v, 6);
        rd(6, v); chk("R13 slpdep", v, 2);
        rd(7, v); chk("R13 wkdep", v, 1);
        wr(1, 0); wr(2, 0); wr(6, 0); wr(7, 0);

        // R3 mode 0 never sleeps
        wr(0, 0); wr(4, 0); wr(5, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R3 mode0 no sleep", pwr_req, 0);
        end

        // R2 sweep over all clock enable patterns
        for (int c = 0; c < 64; c++) begin
            wr(0, 0);
            wr(4, c & 7);
            wr(5, c >> 3);
            wr(0, 3);
            @(negedge clk);
            chk("R2 AND of gates", pwr_req, (c == 0) ? 1 : 0);
            if (c == 0) begin
                chk("R5 clocks off in transition", int'(iclk_en) + int'(fclk_en), 0);
                do_ack();
                chk("R5 retention", pwr_state, 2);
                force_wake();
            end else begin
                wr(0, 0);
            end
        end

        // R4 sleep dependency, R3 forced sleep, R10 wake dependency
        wr(6, 1);
        dom_busy = 2'b01;
        wr(0, 0); wr(4, 0); wr(5, 0); wr(0, 3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 dependency blocks", pwr_req, 0);
        end
        dom_busy = 2'b10;
        @(negedge clk);
        chk("R4 unmasked busy ignored", pwr_req, 1);
        do_ack();
        force_wake();
        dom_busy = 2'b01;
        wr(0, 0); wr(4, 0); wr(5, 0); wr(0, 1);
        @(negedge clk);
        chk("R3 forced sleep ignores dependency", pwr_req, 1);
        do_ack();
        chk("R3 forced sleep retention", pwr_state, 2);
        wr(7, 2);
        dom_wake = 2'b01;
        @(negedge clk);
        dom_wake = 2'b00;
        chk("R10 unmasked wake ignored", pwr_state, 2);
        dom_wake = 2'b10;
        @(negedge clk);
        dom_wake = 2'b00;
        chk("R10 dep wake moving", pwr_state, 1);
        chk("R7 iclk first", iclk_en, ALL_M);
        chk("R7 fclk later", fclk_en, 0);
        @(negedge clk);
        chk("R10 dep wake on", pwr_state, 0);
        chk("R7 fclk on", fclk_en, ALL_M);
        dom_busy = '0;
        wr(6, 0); wr(7, 0); wr(0, 0);

        // R5 target latch and hold until ack
        go_sleep(1'b1);
        chk("R5 moving", pwr_state, 1);
        chk("R9 inaccessible in transition", inaccessible, 1);
        wr(0, 3);
        chk("R5 held without ack", pwr_req, 1);
        do_ack();
        chk("R5 off target latched", pwr_state, 3);
        chk("R9 inaccessible off", inaccessible, 1);
        force_wake();

        // R6 qualification sweep, R7, R8, R9
        for (int m = 0; m < NM; m++) begin
            for (int c = 0; c < 4; c++) begin
                go_sleep(1'b0);
                do_ack();
                wr(1, (c & 1) << m);
                wr(2, ((c >> 1) & 1) << m);
                @(negedge clk);
                mod_wake = NM'(1 << m);
                @(negedge clk);
                mod_wake = '0;
                if (c == 3) begin
                    chk("R6 qualified wake", pwr_state, 1);
                    chk("R7 iclk first", iclk_en, ALL_M);
                    chk("R7 fclk still off", fclk_en, 0);
                    chk("R9 inaccessible mid wake", inaccessible, 1);
                    @(negedge clk);
                    chk("R7 fclk second", fclk_en, ALL_M);
                    chk("R9 accessible", inaccessible, 0);
                    rd(3, v); chk("R8 status set", v, 1 << m);
                    wr(3, 0);
                    rd(3, v); chk("R8 status cleared", v, 0);
                end else begin
                    chk("R6 unqualified ignored", pwr_state, 2);
                    rd(3, v); chk("R6 no status", v, 0);
                    force_wake();
                end
                wr(1, 0); wr(2, 0);
            end
        end

        // R12 wake during transition
        wr(1, 1); wr(2, 1);
        go_sleep(1'b0);
        mod_wake = 3'b001;
        @(negedge clk);
        mod_wake = '0;
        chk("R12 still requesting", pwr_req, 1);
        do_ack();
        chk("R12 direct wake", pwr_state, 1);
        chk("R12 iclk first", iclk_en, ALL_M);
        chk("R12 fclk off", fclk_en, 0);
        @(negedge clk);
        chk("R12 back on", pwr_state, 0);
        rd(3, v); chk("R12 status kept", v, 1);
        wr(3, 0);
        wr(1, 0); wr(2, 0);

        // R8 set wins over clear, write 1 keeps
        wr(1, 2); wr(2, 2);
        @(negedge clk);
        mod_wake  = 3'b010;
        reg_we    = 1'b1;
        reg_addr  = 3;
        reg_wdata = '0;
        @(negedge clk);
        mod_wake = '0;
        reg_we   = 1'b0;
        rd(3, v); chk("R8 set beats clear", v, 2);
        wr(3, 7);
        rd(3, v); chk("R8 write one keeps", v, 2);
        wr(3, 5);
        rd(3, v); chk("R8 write zero clears", v, 0);
        chk("R9 on accessible", inaccessible, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule